// File: doc/BRIEF.md
# UART Prioritized Interrupt Controller

This block gathers the interrupt conditions of one UART channel and presents them to software. It latches event pulses from the line status, modem status, receive timeout, transmit level, Xoff/special-character detection and auto flow-control logic. It gates each condition with its enable bit. It picks the most urgent enabled condition and reports it as a 6-bit status code. It also drives one interrupt request line. Each source has its own clearing rule: a read of a status register, a data access, or a later received character.

The status code is combinational from the latched state, so a register read returns it in the same cycle. A status-register read acknowledges only the condition that the read reported. Conditions of lower priority stay pending and appear on later reads. The block has no data stream, so all pins are plain control and status signals. Every strobe input is a single-cycle pulse, sampled on the rising clock edge.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, isr_code is 0x01, irq is 0 and no condition is pending. The transmit and flow-control edge detectors are primed so that levels present at reset do not raise an interrupt.
- R2: With several enabled conditions pending, isr_code reports only the highest of them. Priority runs from highest to lowest as follows, with these codes: line status 0x06, receive timeout 0x0C, receive data 0x04, transmit ready 0x02, modem status 0x00, Xoff/special 0x10, flow-control pins 0x20. Servicing the reported condition exposes the next one.
- R3: Any set bit of ls_evt latches the line-status condition. lsr_rd clears it.
- R4: The receive-data condition follows rx_at_trig directly. It is not latched, and no read strobe clears it.
- R5: rx_tmo_evt latches the receive-timeout condition. rhr_rd clears it.
- R6: A rising edge of tx_at_thr latches transmit ready. A level that stays high does not set it again. thr_wr clears it. isr_rd clears it only when the read reported code 0x02.
- R7: Any set bit of ms_evt latches the modem-status condition. msr_rd clears it, together with both flow-control conditions.
- R8: xoff_evt and spc_evt latch into the shared level 0x10. isr_rd clears both, but only when the read reported 0x10. xon_evt clears only the Xoff part, and rx_char clears only the special-character part.
- R9: A LOW-to-HIGH edge of rts_pin or cts_pin latches a condition only while enh_mode and the matching auto flow-control enable (afc_rts_en, afc_cts_en) are both 1.
- R10: The ier bits are mapped as follows: bit0 enables receive data and timeout, bit1 transmit, bit2 line status, bit3 modem status, bit5 Xoff/special, bit6 RTS and bit7 CTS. Bits 5 to 7 take effect only with enh_mode=1. A masked condition is not reported, but it stays latched and appears as soon as its enable is set.
- R11: irq is 1 exactly when at least one enabled condition is pending, which is when isr_code differs from 0x01.
- R12: When a set event and a clear strobe for the same condition arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enh_mode | input | 1 | Enhanced mode; unlocks ier bits 5 to 7 |
| afc_rts_en | input | 1 | Auto RTS flow control active |
| afc_cts_en | input | 1 | Auto CTS flow control active |
| ier | input | 8 | Interrupt enable bits |
| ls_evt | input | 4 | Line-status error event pulses |
| ms_evt | input | 4 | Modem-status change event pulses |
| rx_at_trig | input | 1 | Receive FIFO at or above trigger level |
| rx_tmo_evt | input | 1 | Receive timeout expiry pulse |
| tx_at_thr | input | 1 | Transmit FIFO at threshold or empty |
| xoff_evt | input | 1 | Xoff character detected |
| xon_evt | input | 1 | Xon character detected |
| spc_evt | input | 1 | Special character detected |
| rx_char | input | 1 | Any character received |
| rts_pin | input | 1 | RTS pin level |
| cts_pin | input | 1 | CTS pin level |
| isr_rd | input | 1 | Status register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| rhr_rd | input | 1 | Receive holding register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| isr_code | output | 6 | Highest-priority status code |
| irq | output | 1 | Interrupt request |

## Verification
A latched condition shows on isr_code and irq one clock edge after its event pulse or pin edge. A clear takes effect one edge after its strobe. Enable changes and the receive-data level act in the same cycle, with no edge between. The bench drives inputs on the falling edge and samples one falling edge later, so every check sees exactly one rising edge between stimulus and result. Service steps split the status read from the other clears, so each read acknowledges only the code it returned.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NLVL  = 7;
  localparam int LS_W  = 4;
  localparam int MS_W  = 4;
  localparam int IER_W = 8;
  localparam int CW    = 6;

  typedef enum logic [2:0] {
    LV_LS  = 3'd0,
    LV_RTO = 3'd1,
    LV_RXD = 3'd2,
    LV_TX  = 3'd3,
    LV_MS  = 3'd4,
    LV_XS  = 3'd5,
    LV_FC  = 3'd6
  } lvl_e;

  localparam logic [CW-1:0] CODE_NONE = 6'h01;

  function automatic logic [CW-1:0] code_of(input int lvl);
    case (lvl)
      0:       return 6'h06;
      1:       return 6'h0C;
      2:       return 6'h04;
      3:       return 6'h02;
      4:       return 6'h00;
      5:       return 6'h10;
      default: return 6'h20;
    endcase
  endfunction
endpackage

// File: rtl/irq_sources.sv
module irq_sources
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enh_mode,
  input  logic             afc_rts_en,
  input  logic             afc_cts_en,
  input  logic [IER_W-1:0] ier,
  input  logic [LS_W-1:0]  ls_evt,
  input  logic [MS_W-1:0]  ms_evt,
  input  logic             rx_at_trig,
  input  logic             rx_tmo_evt,
  input  logic             tx_at_thr,
  input  logic             xoff_evt,
  input  logic             xon_evt,
  input  logic             spc_evt,
  input  logic             rx_char,
  input  logic             rts_pin,
  input  logic             cts_pin,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  input  logic             rhr_rd,
  input  logic             thr_wr,
  input  logic             ack_tx,
  input  logic             ack_xs,
  output logic [NLVL-1:0]  act
);
  logic ls_p, rto_p, tx_p, ms_p, xoff_p, spc_p, rts_p, cts_p;
  logic tx_q, rts_q, cts_q;
  logic tx_rise, rts_rise, cts_rise;
  logic unused_ier4;

  assign unused_ier4 = ier[4];
  assign tx_rise  = tx_at_thr & ~tx_q;
  assign rts_rise = rts_pin & ~rts_q & enh_mode & afc_rts_en;
  assign cts_rise = cts_pin & ~cts_q & enh_mode & afc_cts_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ls_p <= 1'b0; rto_p <= 1'b0; tx_p <= 1'b0; ms_p <= 1'b0;
      xoff_p <= 1'b0; spc_p <= 1'b0; rts_p <= 1'b0; cts_p <= 1'b0;
      tx_q <= 1'b1; rts_q <= 1'b1; cts_q <= 1'b1;
    end else begin
      tx_q   <= tx_at_thr;
      rts_q  <= rts_pin;
      cts_q  <= cts_pin;
      ls_p   <= (|ls_evt) | (ls_p & ~lsr_rd);
      rto_p  <= rx_tmo_evt | (rto_p & ~rhr_rd);
      tx_p   <= tx_rise | (tx_p & ~thr_wr & ~ack_tx);
      ms_p   <= (|ms_evt) | (ms_p & ~msr_rd);
      xoff_p <= xoff_evt | (xoff_p & ~xon_evt & ~ack_xs);
      spc_p  <= spc_evt | (spc_p & ~rx_char & ~ack_xs);
      rts_p  <= rts_rise | (rts_p & ~msr_rd);
      cts_p  <= cts_rise | (cts_p & ~msr_rd);
    end
  end

  always_comb begin
    act         = '0;
    act[LV_LS]  = ls_p & ier[2];
    act[LV_RTO] = rto_p & ier[0];
    act[LV_RXD] = rx_at_trig & ier[0];
    act[LV_TX]  = tx_p & ier[1];
    act[LV_MS]  = ms_p & ier[3];
    act[LV_XS]  = (xoff_p | spc_p) & ier[5] & enh_mode;
    act[LV_FC]  = ((rts_p & ier[6]) | (cts_p & ier[7])) & enh_mode;
  end

  assert_lsr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && ls_evt == '0) |=> !ls_p);
  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tmo_evt && rhr_rd) |=> rto_p);
  assert_tx_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_p && !thr_wr && !ack_tx) |=> tx_p);
  assert_fc_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enh_mode && !rts_p && !cts_p) |=> (!rts_p && !cts_p));
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] act,
  output logic [NLVL-1:0] sel,
  output logic [CW-1:0]   code
);
  logic found;

  always_comb begin
    sel   = '0;
    code  = CODE_NONE;
    found = 1'b0;
    for (int i = 0; i < NLVL; i++) begin
      if (act[i] && !found) begin
        sel[i] = 1'b1;
        code   = code_of(i);
        found  = 1'b1;
      end
    end
  end

  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
  assert_grant_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel & ~act) == '0));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enh_mode,
  input  logic       afc_rts_en,
  input  logic       afc_cts_en,
  input  logic [7:0] ier,
  input  logic [3:0] ls_evt,
  input  logic [3:0] ms_evt,
  input  logic       rx_at_trig,
  input  logic       rx_tmo_evt,
  input  logic       tx_at_thr,
  input  logic       xoff_evt,
  input  logic       xon_evt,
  input  logic       spc_evt,
  input  logic       rx_char,
  input  logic       rts_pin,
  input  logic       cts_pin,
  input  logic       isr_rd,
  input  logic       lsr_rd,
  input  logic       msr_rd,
  input  logic       rhr_rd,
  input  logic       thr_wr,
  output logic [5:0] isr_code,
  output logic       irq
);
  logic [NLVL-1:0] act;
  logic [NLVL-1:0] sel;
  logic            ack_tx, ack_xs;

  assign ack_tx = isr_rd & sel[LV_TX];
  assign ack_xs = isr_rd & sel[LV_XS];
  assign irq    = |act;

  irq_sources u_src (
    .clk(clk), .rst_n(rst_n), .enh_mode(enh_mode),
    .afc_rts_en(afc_rts_en), .afc_cts_en(afc_cts_en), .ier(ier),
    .ls_evt(ls_evt), .ms_evt(ms_evt), .rx_at_trig(rx_at_trig),
    .rx_tmo_evt(rx_tmo_evt), .tx_at_thr(tx_at_thr), .xoff_evt(xoff_evt),
    .xon_evt(xon_evt), .spc_evt(spc_evt), .rx_char(rx_char),
    .rts_pin(rts_pin), .cts_pin(cts_pin), .lsr_rd(lsr_rd),
    .msr_rd(msr_rd), .rhr_rd(rhr_rd), .thr_wr(thr_wr),
    .ack_tx(ack_tx), .ack_xs(ack_xs), .act(act)
  );

  irq_prio u_prio (
    .clk(clk), .rst_n(rst_n), .act(act), .sel(sel), .code(isr_code)
  );

  assert_irq_matches_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (isr_code != CODE_NONE));
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (isr_code == CODE_NONE && !irq));
endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enh_mode, afc_rts_en, afc_cts_en;
  logic [7:0] ier;
  logic [3:0] ls_evt, ms_evt;
  logic rx_at_trig, rx_tmo_evt, tx_at_thr, xoff_evt, xon_evt, spc_evt, rx_char;
  logic rts_pin, cts_pin, isr_rd, lsr_rd, msr_rd, rhr_rd, thr_wr;
  logic [5:0] isr_code;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_irq_ctrl i_uart_irq_ctrl (.*);

  function automatic logic [5:0] lvl_code(input int l);
    case (l)
      0: return 6'h06; 1: return 6'h0C; 2: return 6'h04; 3: return 6'h02;
      4: return 6'h00; 5: return 6'h10; 6: return 6'h20; default: return 6'h01;
    endcase
  endfunction

  function automatic int top_lvl(input logic [6:0] m);
    for (int i = 0; i < 7; i++) if (m[i]) return i;
    return 7;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [6:0] m);
    chk(req, {1'b0, isr_code}, {1'b0, lvl_code(top_lvl(m))});
    chk(req, {6'b0, irq}, {6'b0, m != 0});
  endtask

  task automatic idle_in();
    ls_evt = 0; ms_evt = 0; rx_tmo_evt = 0; xoff_evt = 0; xon_evt = 0;
    spc_evt = 0; rx_char = 0; isr_rd = 0; lsr_rd = 0; msr_rd = 0;
    rhr_rd = 0; thr_wr = 0;
  endtask

  task automatic do_reset();
    idle_in();
    rx_at_trig = 0; tx_at_thr = 0; rts_pin = 0; cts_pin = 0;
    enh_mode = 1; afc_rts_en = 1; afc_cts_en = 1; ier = 8'hEF;
    rst_n = 0; step(); step(); rst_n = 1; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: idle after reset
    chk_state("R1", 7'h0);

    // R2 sweep: every combination of pending levels, then service in order
    for (int m = 0; m < 128; m++) begin
      logic [6:0] p;
      do_reset();
      p = m[6:0];
      ls_evt = {3'b0, p[0]}; rx_tmo_evt = p[1]; rx_at_trig = p[2];
      tx_at_thr = p[3]; ms_evt = {3'b0, p[4]}; xoff_evt = p[5]; rts_pin = p[6];
      step(); idle_in();
      chk_state("R2", p);
      for (int k = 0; k < 7 && p != 0; k++) begin
        int l;
        l = top_lvl(p);
        isr_rd = 1; step(); isr_rd = 0;
        if (l == 3 || l == 5) p[l] = 1'b0;
        chk_state("R2", p);
        if (p[l]) begin
          case (l)
            0: lsr_rd = 1;
            1: rhr_rd = 1;
            2: rx_at_trig = 0;
            default: msr_rd = 1;
          endcase
          step(); idle_in();
          if (l == 4 || l == 6) begin p[4] = 1'b0; p[6] = 1'b0; end
          else p[l] = 1'b0;
          chk_state(l == 0 ? "R3" : l == 1 ? "R5" : l == 2 ? "R4" : "R7", p);
        end
      end
    end

    // R4: level follows input in same cycle
    do_reset();
    rx_at_trig = 1; #1 chk_state("R4", 7'h04);
    isr_rd = 1; lsr_rd = 1; msr_rd = 1; rhr_rd = 1; step(); idle_in();
    chk_state("R4", 7'h04);
    rx_at_trig = 0; #1 chk_state("R4", 7'h00);

    // R6: held level does not re-set; new edge does; thr_wr clears
    do_reset();
    tx_at_thr = 1; step(); chk_state("R6", 7'h08);
    thr_wr = 1; step(); idle_in(); step(); chk_state("R6", 7'h00);
    tx_at_thr = 0; step(); tx_at_thr = 1; step(); chk_state("R6", 7'h08);
    // R6: read reporting a higher level leaves tx pending
    ls_evt = 4'h8; step(); idle_in();
    isr_rd = 1; step(); idle_in(); chk_state("R6", 7'h09);

    // R12: set and clear in the same cycle
    do_reset();
    ls_evt = 4'h2; step(); ls_evt = 4'h4; lsr_rd = 1; step(); idle_in();
    chk_state("R12", 7'h01);

    // R8: xon clears Xoff only; rx_char clears special only
    do_reset();
    xoff_evt = 1; spc_evt = 1; step(); idle_in();
    xon_evt = 1; step(); idle_in(); chk_state("R8", 7'h20);
    rx_char = 1; step(); idle_in(); chk_state("R8", 7'h00);
    spc_evt = 1; step(); idle_in(); xon_evt = 1; step(); idle_in();
    chk_state("R8", 7'h20);

    // R9: no edge captured without enhanced mode or auto flow enable
    do_reset();
    enh_mode = 0; rts_pin = 1; cts_pin = 1; step();
    enh_mode = 1; step(); chk_state("R9", 7'h00);
    rts_pin = 0; cts_pin = 0; afc_cts_en = 0; step();
    cts_pin = 1; step(); chk_state("R9", 7'h00);
    rts_pin = 1; step(); chk_state("R9", 7'h40);

    // R10: masked condition retained; bits 5..7 need enhanced mode
    do_reset();
    ier = 8'h00; ls_evt = 4'h1; ms_evt = 4'h2; step(); idle_in();
    chk_state("R10", 7'h00);
    ier = 8'h08; #1 chk_state("R10", 7'h10);
    ier = 8'h0C; #1 chk_state("R10", 7'h11);
    ier = 8'h20; xoff_evt = 1; step(); idle_in(); chk_state("R10", 7'h20);
    enh_mode = 0; #1 chk_state("R10", 7'h00);
    ier = 8'h01; enh_mode = 1; rx_at_trig = 1; #1 chk_state("R11", 7'h04);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule